// File: doc/BRIEF.md
# Disk Address Advance and Capacity Check

This unit runs once at the end of a disk data transfer. It takes the drive's starting position (cylinder, and a combined track/sector word), the transfer length in bytes and the drive geometry. From these it works out how many 16-bit words can actually move. It then works out where the heads stand once the transfer is over. Each sector holds 256 words.

The byte count is turned into words, rounding up. When a transfer would run past the last word of the disk, the count is cut back to the words that remain and an overflow error is raised. When no words remain at all, an exception is raised, no words move and the position is left alone. The end position is rounded up to a whole sector. The unit then splits it back into cylinder, track and sector with a shared bit-serial divider, used twice. It also reports the padded word count that a write stores with its last sector zero-filled, and a flag that the end of the disk has been reached.

All inputs are sampled on the cycle `start_i` is seen while the unit is idle. Results are held until the next run, and a one-cycle `done_o` marks them valid.

Top module: `disk_addr_adv`

## Requirements
- R1: With no overflow, `wc_o` equals the byte count divided by two, rounded up (an odd byte adds a whole word).
- R2: The start word address is ((cylinder × surfaces + track) × sectors + sector) × 256, and the capacity is cylinders × surfaces × sectors × 256. When start plus words exceeds the capacity, `aoe_o` is 1 and `wc_o` is capacity minus start.
- R3: When R2's overflow occurs and the start is at or beyond the capacity, `exc_o` and `aoe_o` are 1, `wc_o` and `pad_o` are 0, `last_o` is 0, and `cyl_o`/`da_o` return the start cylinder, track and sector unchanged.
- R4: Otherwise the next block is (start + `wc_o` + 255) / 256. The outputs are sector = block mod sectors, track = (block / sectors) mod surfaces and cylinder = block / (sectors × surfaces). In `da_i` and `da_o` the sector sits in bits 5:0 and the track in bits 13:8. Bits 7:6 and 15:14 of `da_i` are ignored and read back as 0 in `da_o`.
- R5: A transfer that ends part-way into a sector advances the position past that whole sector. A transfer that ends exactly on a sector boundary does not advance further.
- R6: `last_o` is 1 when the rounded end word address (start + `wc_o` + 255) is at or beyond the capacity; a trimmed transfer therefore always sets it.
- R7: With `write_i` = 1, `pad_o` is `wc_o` rounded up to a multiple of 256. With `write_i` = 0, `pad_o` equals `wc_o`.
- R8: After reset all outputs are 0. Every run produces exactly one `done_o` pulse, one cycle wide, with all results valid in that cycle.
- R9: A `start_i` that arrives while a run is in progress is ignored. It produces no extra `done_o`, and the running computation uses the inputs sampled at its own start.
- R10: A zero byte count yields `wc_o` = 0 and a next position equal to the start position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; sampled only while idle |
| write_i | input | 1 | Transfer is a write (selects padded count) |
| cyl_i | input | CYL_W | Start cylinder |
| da_i | input | 16 | Start track (13:8) and sector (5:0) |
| bytes_i | input | BC_W | Transfer length in bytes |
| geo_sect_i | input | SEC_W | Sectors per track |
| geo_surf_i | input | TRK_W | Surfaces (tracks per cylinder) |
| geo_cyl_i | input | CYL_W | Cylinders on the drive |
| done_o | output | 1 | One-cycle result strobe |
| wc_o | output | BC_W | Words actually transferred |
| pad_o | output | BC_W | Words stored including zero fill |
| da_o | output | 16 | Next track (13:8) and sector (5:0) |
| cyl_o | output | CYL_W | Next cylinder |
| last_o | output | 1 | End of disk reached |
| aoe_o | output | 1 | Address overflow, transfer trimmed |
| exc_o | output | 1 | Nothing left to transfer |

## Verification
The assertions take for granted that all three geometry inputs are non-zero whenever a run starts; a zero divisor would let the divider remainder exceed its bound. They also take the byte count to stay within `BC_W`, so that the rounded word count cannot wrap. The stimulus uses only drive geometries with non-zero sectors, surfaces and cylinders. Start addresses beyond the last cylinder or surface are still driven on purpose to exercise the exception path, since nothing in the unit needs the start fields to lie inside the geometry.

// File: rtl/adv_pkg.sv
package adv_pkg;
  localparam int unsigned SECT_WORDS_LOG = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LIN,
    ST_DV1,
    ST_DV2
  } adv_state_e;
endpackage

// File: rtl/adv_linear.sv
module adv_linear #(
  parameter int unsigned CYL_W   = 10,
  parameter int unsigned TRK_W   = 6,
  parameter int unsigned SEC_W   = 6,
  parameter int unsigned BC_W    = 17,
  parameter int unsigned WPS_LOG = 8
) (
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [TRK_W-1:0] trk_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] nsec_i,
  input  logic [TRK_W-1:0] nsurf_i,
  input  logic [CYL_W-1:0] ncyl_i,
  input  logic [BC_W-1:0]  bytes_i,
  input  logic             write_i,
  output logic [BC_W-1:0]  wc_o,
  output logic [BC_W-1:0]  pad_o,
  output logic             aoe_o,
  output logic             exc_o,
  output logic             last_o,
  output logic [CYL_W+TRK_W+SEC_W+2:0] end_blk_o
);
  localparam int unsigned BLK_W = CYL_W + TRK_W + SEC_W + 2;
  localparam int unsigned WA_W  = BLK_W + WPS_LOG + 1;
  localparam int unsigned WPS   = 1 << WPS_LOG;

  logic [BLK_W-1:0] cyl_x, trk_x, sec_x, nsec_x, nsurf_x, ncyl_x;
  logic [BLK_W-1:0] start_blk, cap_blk;
  logic [WA_W-1:0]  start_wa, cap_wa, sum_wa, room_wa, end_wa;
  logic [BC_W:0]    bc_p1;
  logic [BC_W-1:0]  words, wc, wc_up;
  logic             ovf;

  assign cyl_x   = BLK_W'(cyl_i);
  assign trk_x   = BLK_W'(trk_i);
  assign sec_x   = BLK_W'(sec_i);
  assign nsec_x  = BLK_W'(nsec_i);
  assign nsurf_x = BLK_W'(nsurf_i);
  assign ncyl_x  = BLK_W'(ncyl_i);

  assign start_blk = (cyl_x * nsurf_x + trk_x) * nsec_x + sec_x;
  assign cap_blk   = ncyl_x * nsurf_x * nsec_x;
  assign start_wa  = WA_W'({start_blk, {WPS_LOG{1'b0}}});
  assign cap_wa    = WA_W'({cap_blk, {WPS_LOG{1'b0}}});

  // round odd byte up to a full word
  assign bc_p1 = {1'b0, bytes_i} + (BC_W+1)'(1);
  assign words = bc_p1[BC_W:1];

  assign sum_wa  = start_wa + WA_W'(words);
  assign ovf     = sum_wa > cap_wa;
  assign exc_o   = ovf && (start_wa >= cap_wa);
  assign aoe_o   = ovf;
  assign room_wa = cap_wa - start_wa;
  assign wc      = !ovf ? words : (exc_o ? '0 : BC_W'(room_wa));
  assign wc_o    = wc;

  assign end_wa    = start_wa + WA_W'(wc) + WA_W'(WPS - 1);
  assign last_o    = !exc_o && (end_wa >= cap_wa);
  assign end_blk_o = end_wa[WA_W-1:WPS_LOG];

  assign wc_up = wc + BC_W'(WPS - 1);
  assign pad_o = write_i ? {wc_up[BC_W-1:WPS_LOG], {WPS_LOG{1'b0}}} : wc;

  logic unused_lin;
  assign unused_lin = ^{bc_p1[0], end_wa[WPS_LOG-1:0]};
endmodule

// File: rtl/adv_div.sv
module adv_div #(
  parameter int unsigned DW = 25,
  parameter int unsigned VW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] num_i,
  input  logic [VW-1:0] den_i,
  output logic [DW-1:0] quo_o,
  output logic [VW-1:0] rem_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q;
  logic [VW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [VW:0]   shl, diff;
  logic          ge;

  assign shl  = {rem_q, quo_q[DW-1]};
  assign ge   = shl >= {1'b0, den_q};
  assign diff = shl - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_q) begin
        quo_q <= {quo_q[DW-2:0], ge};
        rem_q <= ge ? diff[VW-1:0] : shl[VW-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (go_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R4
  rem_lt_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rem_q < den_q);
endmodule

// File: rtl/disk_addr_adv.sv
module disk_addr_adv #(
  parameter int unsigned CYL_W   = 10,
  parameter int unsigned TRK_W   = 6,
  parameter int unsigned SEC_W   = 6,
  parameter int unsigned BC_W    = 17,
  parameter int unsigned WPS_LOG = adv_pkg::SECT_WORDS_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [15:0]      da_i,
  input  logic [BC_W-1:0]  bytes_i,
  input  logic [SEC_W-1:0] geo_sect_i,
  input  logic [TRK_W-1:0] geo_surf_i,
  input  logic [CYL_W-1:0] geo_cyl_i,
  output logic             done_o,
  output logic [BC_W-1:0]  wc_o,
  output logic [BC_W-1:0]  pad_o,
  output logic [15:0]      da_o,
  output logic [CYL_W-1:0] cyl_o,
  output logic             last_o,
  output logic             aoe_o,
  output logic             exc_o
);
  import adv_pkg::*;

  localparam int unsigned DA_W    = 16;
  localparam int unsigned TRK_LSB = 8;
  localparam int unsigned BLK_W   = CYL_W + TRK_W + SEC_W + 2;
  localparam int unsigned DW      = BLK_W + 1;
  localparam int unsigned VW      = (SEC_W > TRK_W) ? SEC_W : TRK_W;
  localparam int unsigned HI_PAD  = DA_W - TRK_LSB - TRK_W;
  localparam int unsigned MID_PAD = TRK_LSB - SEC_W;

  adv_state_e st_q;

  logic [CYL_W-1:0] cyl_q, ncyl_q;
  logic [TRK_W-1:0] trk_q, nsurf_q;
  logic [SEC_W-1:0] sec_q, nsec_q, sec_new_q;
  logic [BC_W-1:0]  bc_q;
  logic             wr_q;

  logic [BC_W-1:0]  lin_wc, lin_pad;
  logic             lin_aoe, lin_exc, lin_last;
  logic [DW-1:0]    lin_end_blk;

  logic [DW-1:0]    div_num_q, div_quo;
  logic [VW-1:0]    div_den_q, div_rem;
  logic             div_go_q, div_done;

  adv_linear #(
    .CYL_W(CYL_W), .TRK_W(TRK_W), .SEC_W(SEC_W), .BC_W(BC_W), .WPS_LOG(WPS_LOG)
  ) u_lin (
    .cyl_i    (cyl_q),
    .trk_i    (trk_q),
    .sec_i    (sec_q),
    .nsec_i   (nsec_q),
    .nsurf_i  (nsurf_q),
    .ncyl_i   (ncyl_q),
    .bytes_i  (bc_q),
    .write_i  (wr_q),
    .wc_o     (lin_wc),
    .pad_o    (lin_pad),
    .aoe_o    (lin_aoe),
    .exc_o    (lin_exc),
    .last_o   (lin_last),
    .end_blk_o(lin_end_blk)
  );

  adv_div #(.DW(DW), .VW(VW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (div_go_q),
    .num_i (div_num_q),
    .den_i (div_den_q),
    .quo_o (div_quo),
    .rem_o (div_rem),
    .done_o(div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cyl_q     <= '0;
      trk_q     <= '0;
      sec_q     <= '0;
      nsec_q    <= '0;
      nsurf_q   <= '0;
      ncyl_q    <= '0;
      bc_q      <= '0;
      wr_q      <= 1'b0;
      sec_new_q <= '0;
      div_num_q <= '0;
      div_den_q <= '0;
      div_go_q  <= 1'b0;
      done_o    <= 1'b0;
      wc_o      <= '0;
      pad_o     <= '0;
      da_o      <= '0;
      cyl_o     <= '0;
      last_o    <= 1'b0;
      aoe_o     <= 1'b0;
      exc_o     <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      div_go_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cyl_q   <= cyl_i;
          trk_q   <= da_i[TRK_LSB +: TRK_W];
          sec_q   <= da_i[SEC_W-1:0];
          nsec_q  <= geo_sect_i;
          nsurf_q <= geo_surf_i;
          ncyl_q  <= geo_cyl_i;
          bc_q    <= bytes_i;
          wr_q    <= write_i;
          st_q    <= ST_LIN;
        end
        ST_LIN: begin
          wc_o   <= lin_wc;
          pad_o  <= lin_pad;
          aoe_o  <= lin_aoe;
          exc_o  <= lin_exc;
          last_o <= lin_last;
          if (lin_exc) begin
            da_o   <= {{HI_PAD{1'b0}}, trk_q, {MID_PAD{1'b0}}, sec_q};
            cyl_o  <= cyl_q;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            div_num_q <= lin_end_blk;
            div_den_q <= VW'(nsec_q);
            div_go_q  <= 1'b1;
            st_q      <= ST_DV1;
          end
        end
        ST_DV1: if (div_done) begin
          sec_new_q <= div_rem[SEC_W-1:0];
          div_num_q <= div_quo;
          div_den_q <= VW'(nsurf_q);
          div_go_q  <= 1'b1;
          st_q      <= ST_DV2;
        end
        ST_DV2: if (div_done) begin
          da_o   <= {{HI_PAD{1'b0}}, div_rem[TRK_W-1:0], {MID_PAD{1'b0}}, sec_new_q};
          cyl_o  <= div_quo[CYL_W-1:0];
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_top;
  assign unused_top = ^{da_i[DA_W-1:TRK_LSB+TRK_W], da_i[TRK_LSB-1:SEC_W]};

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  exc_no_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exc_o) |-> (aoe_o && wc_o == '0 && pad_o == '0 && !last_o));

  // R1
  wc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !aoe_o) |-> wc_o == (bc_q >> 1) + BC_W'(bc_q[0]));

  // R6
  trim_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && aoe_o && !exc_o) |-> last_o);

  // R7
  pad_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wr_q) |-> (pad_o[WPS_LOG-1:0] == '0 && pad_o >= wc_o));

  // R9
  hold_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(bc_q) && $stable(cyl_q) && $stable(nsec_q)));
endmodule

// File: tb/disk_addr_adv_test.sv
`timescale 1ns/1ps
module disk_addr_adv_test;
  localparam int CYL_W = 10;
  localparam int TRK_W = 6;
  localparam int SEC_W = 6;
  localparam int BC_W  = 17;

  typedef struct packed {
    logic [BC_W-1:0]  wc;
    logic [BC_W-1:0]  pad;
    logic [15:0]      da;
    logic [CYL_W-1:0] cyl;
    logic             last;
    logic             aoe;
    logic             exc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wr = 1'b0;
  logic [CYL_W-1:0] cyl_in = '0;
  logic [15:0] da_in = '0;
  logic [BC_W-1:0] bytes_in = '0;
  logic [SEC_W-1:0] gsec = '0;
  logic [TRK_W-1:0] gsurf = '0;
  logic [CYL_W-1:0] gcyl = '0;
  logic done;
  logic [BC_W-1:0] wc, pad;
  logic [15:0] da_out;
  logic [CYL_W-1:0] cyl_out;
  logic last, aoe, exc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  disk_addr_adv uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
    .cyl_i(cyl_in), .da_i(da_in), .bytes_i(bytes_in),
    .geo_sect_i(gsec), .geo_surf_i(gsurf), .geo_cyl_i(gcyl),
    .done_o(done), .wc_o(wc), .pad_o(pad), .da_o(da_out), .cyl_o(cyl_out),
    .last_o(last), .aoe_o(aoe), .exc_o(exc)
  );

  function automatic exp_t model(bit w, int cy, int tr, int se, int bc,
                                 int gse, int gsu, int gcy);
    exp_t e;
    longint words, start_w, cap_w, wcl, endw, blk;
    bit ov, ex;
    words   = (longint'(bc) + 1) / 2;
    start_w = ((longint'(cy) * gsu + tr) * gse + se) * 256;
    cap_w   = longint'(gcy) * gsu * gse * 256;
    ov = (start_w + words) > cap_w;
    ex = ov && (start_w >= cap_w);
    wcl = !ov ? words : (ex ? 0 : cap_w - start_w);
    e.wc = BC_W'(wcl);
    e.aoe = ov;
    e.exc = ex;
    if (ex) begin
      e.pad  = '0;
      e.last = 1'b0;
      e.da   = {2'b00, 6'(tr), 2'b00, 6'(se)};
      e.cyl  = CYL_W'(cy);
    end else begin
      endw   = start_w + wcl + 255;
      e.last = endw >= cap_w;
      blk    = endw / 256;
      e.da   = {2'b00, 6'((blk / gse) % gsu), 2'b00, 6'(blk % gse)};
      e.cyl  = CYL_W'(blk / (longint'(gse) * gsu));
      e.pad  = w ? BC_W'(((wcl + 255) / 256) * 256) : BC_W'(wcl);
    end
    return e;
  endfunction

  task automatic fail(string msg);
    errors++;
    $display("FAIL %s", msg);
  endtask

  task automatic drive(bit w, int cy, int tr, int se, int bc, int gse, int gsu,
                       int gcy, logic [1:0] junk);
    @(negedge clk);
    start    = 1'b1;
    wr       = w;
    cyl_in   = CYL_W'(cy);
    da_in    = {junk, 6'(tr), junk, 6'(se)};
    bytes_in = BC_W'(bc);
    gsec     = SEC_W'(gse);
    gsurf    = TRK_W'(gsu);
    gcyl     = CYL_W'(gcy);
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic run(string tag, bit w, int cy, int tr, int se, int bc,
                     int gse, int gsu, int gcy, logic [1:0] junk);
    exp_q.push_back(model(w, cy, tr, se, bc, gse, gsu, gcy));
    tag_q.push_back(tag);
    drive(w, cy, tr, se, bc, gse, gsu, gcy, junk);
    for (int i = 0; i < 1000 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  // monitor: pop and compare on each result strobe
  initial begin
    exp_t e, g;
    string t;
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        checks++;
        if (exp_q.size() == 0) begin
          fail("R9 unexpected done with nothing pending");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          g = '{wc, pad, da_out, cyl_out, last, aoe, exc};
          if (g !== e)
            fail($sformatf("%s got wc=%0d pad=%0d da=%h cyl=%0d last=%b aoe=%b exc=%b exp wc=%0d pad=%0d da=%h cyl=%0d last=%b aoe=%b exc=%b",
              t, g.wc, g.pad, g.da, g.cyl, g.last, g.aoe, g.exc,
              e.wc, e.pad, e.da, e.cyl, e.last, e.aoe, e.exc));
        end
        @(negedge clk);
        checks++;
        if (done !== 1'b0) fail($sformatf("R8 done width got=%b exp=0", done));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if ({done, wc, pad, da_out, cyl_out, last, aoe, exc} !== '0)
      fail($sformatf("R8 reset outputs got=%h exp=0",
        {done, wc, pad, da_out, cyl_out, last, aoe, exc}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R1 R4 two whole sectors",      0, 10, 2, 5, 1024, 32, 5, 823, 2'b00);
    run("R5 R7 partial sector write",   1, 10, 2, 5, 3, 32, 5, 823, 2'b00);
    run("R10 zero length",              0, 7, 4, 31, 0, 32, 5, 823, 2'b00);
    run("R1 R5 odd byte count",         0, 0, 0, 0, 513, 32, 5, 823, 2'b00);
    run("R4 track and cylinder wrap",   0, 5, 18, 21, 512, 22, 19, 411, 2'b00);
    run("R4 spare da bits ignored",     0, 3, 1, 2, 2048, 22, 19, 411, 2'b11);
    run("R2 R6 trimmed at end",         0, 2, 1, 3, 2048, 4, 2, 3, 2'b00);
    run("R6 exact end no overflow",     0, 2, 1, 2, 1024, 4, 2, 3, 2'b00);
    run("R3 start at capacity",         1, 3, 0, 0, 2, 4, 2, 3, 2'b00);
    run("R3 start past capacity",       0, 2, 5, 1, 100, 4, 2, 3, 2'b10);
    run("R6 R10 zero at capacity",      0, 3, 0, 0, 0, 4, 2, 3, 2'b00);
    run("R7 write aligned length",      1, 1, 1, 1, 1024, 4, 2, 3, 2'b00);
    run("R7 read no padding",           0, 1, 1, 1, 601, 4, 2, 3, 2'b00);
    run("R1 R4 maximum length",         1, 0, 0, 0, 131071, 32, 5, 823, 2'b00);
    run("R2 large drive overflow",      0, 629, 31, 49, 4000, 50, 32, 630, 2'b00);

    // R9: second start during a run must be ignored
    exp_q.push_back(model(0, 4, 3, 7, 777, 32, 5, 823));
    tag_q.push_back("R9 first run kept");
    drive(0, 4, 3, 7, 777, 32, 5, 823, 2'b00);
    repeat (4) @(negedge clk);
    drive(1, 2, 1, 3, 4096, 4, 2, 3, 2'b00);
    for (int i = 0; i < 1000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (120) @(negedge clk);

    checks++;
    if (exp_q.size() != 0)
      fail($sformatf("R8 pending results got=%0d exp=0", exp_q.size()));

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule